// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execution stage of a small accumulator-style microcontroller datapath. Each cycle it receives an operation code, the working register value it holds internally (W), an operand read from the register file (f), an 8-bit literal, a bit index and a destination select. It forms the result of add, decrement, move, clear, bit-clear and bit-test operations and returns it either to W or to the register file through a write port, all while keeping a status register of five flags.

Register-file writes, the skip indication and the result data are combinational in the cycle the execute strobe is high; W and the status register update on the rising edge of that cycle. Two branch-condition outputs, taken straight from the stored flags, tell a sequencer whether the last flag-setting result was non-zero and whether it overflowed as a signed value.

Top module: `acc_alu_core`

## Requirements
- R1: A clock edge with rst_n low sets W to 0x00 and the status register to 0x00.
- R2: Status layout: bit 0 is C (carry out of bit 7), bit 1 is DC (carry out of bit 3), bit 2 is Z (result zero), bit 3 is OV (signed overflow), bit 4 is N (result bit 7); bits 7:5 always read 0.
- R3: op 0 adds W and f, op 7 adds W and the literal; both update all five flags from the 8-bit addition.
- R4: op 1 decrements f, computed as f + 0xFF, so C, DC, Z, OV and N all follow the addition rule.
- R5: For ops 0, 1 and 2, dest_i = 0 sends the result to W at the clock edge and dest_i = 1 raises file_we_o with the result on file_wr_o in the same cycle, leaving W unchanged.
- R6: op 2 (move f) and op 3 (clear f) change only Z and N; op 3 writes 0x00 to f whatever dest_i is.
- R7: op 6 loads the literal into W and leaves every flag unchanged.
- R8: op 4 writes f with the bit named by bit_idx_i cleared and the other bits kept, and leaves every flag unchanged, including Z when the result is zero.
- R9: op 5 raises skip_o in the execute cycle when the indexed bit of f is 0, writes neither W nor f and leaves the flags unchanged.
- R10: br_nz_o equals the inverse of the stored Z flag and br_ov_o equals the stored OV flag.
- R11: While exec_i is low, W and status hold their values and file_we_o and skip_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe for the presented operation |
| op_i | input | 3 | Operation code |
| dest_i | input | 1 | Destination select, 0 = W, 1 = f |
| file_rd_i | input | 8 | File-register operand |
| lit_i | input | 8 | Literal operand |
| bit_idx_i | input | 3 | Bit index for bit operations |
| w_o | output | 8 | Working register value |
| status_o | output | 8 | Status register |
| file_we_o | output | 1 | File-register write enable |
| file_wr_o | output | 8 | File-register write data |
| skip_o | output | 1 | Skip-next indication from bit test |
| br_nz_o | output | 1 | Branch condition: result not zero |
| br_ov_o | output | 1 | Branch condition: overflow |

## Verification
A bit test can fire its skip in the very cycle the branch outputs are still reporting flags left by an earlier addition, and a move can rewrite Z and N while C, DC and OV from that addition must survive. The bench provokes both by executing a signed-overflowing add to set C, Z and OV, then a bit test on a cleared bit and a move, checking skip_o during the execute cycle and then confirming the status value and branch outputs still carry the preserved flags. Every table vector additionally starts from a cleared status so flag updates are judged against hand-computed values.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes and status-bit positions for the
// accumulator ALU. Assumes an 8-bit status register.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_WF  = 3'd0,
        OP_DEC_F   = 3'd1,
        OP_MOVE_F  = 3'd2,
        OP_CLEAR_F = 3'd3,
        OP_BIT_CLR = 3'd4,
        OP_BIT_TST = 3'd5,
        OP_LOAD_L  = 3'd6,
        OP_ADD_L   = 3'd7
    } alu_op_t;

    localparam int STAT_W  = 8;
    localparam int FLG_C   = 0;
    localparam int FLG_DC  = 1;
    localparam int FLG_Z   = 2;
    localparam int FLG_OV  = 3;
    localparam int FLG_N   = 4;
    localparam int FLG_CNT = 5;

endpackage

// File: rtl/acc_alu_adder.sv
// Module: two-operand adder producing the sum with carry, half carry and
// signed overflow. Assumes DATA_W is even so the low half is a nibble-style
// split at DATA_W/2.
module acc_alu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              half_carry_o,
    output logic              ovf_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full_sum;
    logic [HALF_W:0] low_sum;

    // Purpose: full-width and low-half additions.
    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i};
        low_sum  = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]};
    end

    // Purpose: flag extraction from the additions.
    always_comb begin
        sum_o        = full_sum[DATA_W-1:0];
        carry_o      = full_sum[DATA_W];
        half_carry_o = low_sum[HALF_W];
        ovf_o        = (a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                       (full_sum[DATA_W-1] != a_i[DATA_W-1]);
    end

    // R3: overflow only when operands agree in sign and the sum sign differs
    always_comb begin
        add_ovf_sign_chk: assert (!ovf_o || (a_i[DATA_W-1] == b_i[DATA_W-1] &&
                                  sum_o[DATA_W-1] != b_i[DATA_W-1]))
            else $error("overflow flag inconsistent with operand signs");
    end

endmodule

// File: rtl/acc_alu_bitops.sv
// Module: bit-clear and bit-test of the file operand at a given index.
// Assumes the index is always within the operand width.
module acc_alu_bitops #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] f_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] cleared_o,
    output logic              bit_val_o
);
    logic [DATA_W-1:0] sel_mask;

    // Purpose: one-hot decoder of the bit index, one slice per bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign sel_mask[g] = (idx_i == IDX_W'(g));
    end

    // Purpose: clear the selected bit and pick it out for testing.
    always_comb begin
        cleared_o = f_i & ~sel_mask;
        bit_val_o = |(f_i & sel_mask);
    end

    // R8: bit-clear touches at most one bit and leaves it zero
    always_comb begin
        bit_clr_single_chk: assert ($countones(cleared_o ^ f_i) <= 1 &&
                                    (cleared_o & sel_mask) == '0)
            else $error("bit clear changed more than the selected bit");
    end

endmodule

// File: rtl/acc_alu_decode.sv
// Module: turns the operation code and destination bit into write enables
// and flag-update classes. Assumes op codes from acc_alu_pkg.
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  alu_op_t op_i,
    input  logic    dest_i,
    output logic    wr_w_o,
    output logic    wr_f_o,
    output logic    upd_all_o,
    output logic    upd_zn_o
);
    // Purpose: per-operation destination and flag class.
    always_comb begin
        wr_w_o    = 1'b0;
        wr_f_o    = 1'b0;
        upd_all_o = 1'b0;
        upd_zn_o  = 1'b0;
        unique case (op_i)
            OP_ADD_WF, OP_DEC_F: begin
                wr_w_o    = !dest_i;
                wr_f_o    = dest_i;
                upd_all_o = 1'b1;
            end
            OP_MOVE_F: begin
                wr_w_o   = !dest_i;
                wr_f_o   = dest_i;
                upd_zn_o = 1'b1;
            end
            OP_CLEAR_F: begin
                wr_f_o   = 1'b1;
                upd_zn_o = 1'b1;
            end
            OP_BIT_CLR: wr_f_o = 1'b1;
            OP_BIT_TST: ;
            OP_LOAD_L:  wr_w_o = 1'b1;
            OP_ADD_L: begin
                wr_w_o    = 1'b1;
                upd_all_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: a result never goes to both W and f
    always_comb begin
        dest_excl_chk: assert (!(wr_w_o && wr_f_o))
            else $error("result routed to both destinations");
    end

endmodule

// File: rtl/acc_alu_core.sv
// Module: accumulator ALU top. Holds W and the status register, selects
// adder operands, muxes the result and routes it to W or the file port.
// Assumes the file operand is valid whenever exec_i is high.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [2:0]        op_i,
    input  logic              dest_i,
    input  logic [DATA_W-1:0] file_rd_i,
    input  logic [DATA_W-1:0] lit_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic [DATA_W-1:0] w_o,
    output logic [STAT_W-1:0] status_o,
    output logic              file_we_o,
    output logic [DATA_W-1:0] file_wr_o,
    output logic              skip_o,
    output logic              br_nz_o,
    output logic              br_ov_o
);
    alu_op_t           op;
    logic [DATA_W-1:0] w_q;
    logic [FLG_CNT-1:0] flags_q, flags_d;
    logic [DATA_W-1:0] add_a, add_b, add_sum, bclr_res, result;
    logic              add_c, add_dc, add_ov, bit_val;
    logic              wr_w, wr_f, upd_all, upd_zn;
    logic              res_zero;

    assign op = alu_op_t'(op_i);

    acc_alu_decode u_decode (
        .op_i      (op),
        .dest_i    (dest_i),
        .wr_w_o    (wr_w),
        .wr_f_o    (wr_f),
        .upd_all_o (upd_all),
        .upd_zn_o  (upd_zn)
    );

    // Purpose: adder operand selection (decrement adds all-ones).
    always_comb begin
        add_a = (op == OP_DEC_F) ? file_rd_i : w_q;
        unique case (op)
            OP_ADD_WF: add_b = file_rd_i;
            OP_DEC_F:  add_b = '1;
            default:   add_b = lit_i;
        endcase
    end

    acc_alu_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i          (add_a),
        .b_i          (add_b),
        .sum_o        (add_sum),
        .carry_o      (add_c),
        .half_carry_o (add_dc),
        .ovf_o        (add_ov)
    );

    acc_alu_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitops (
        .f_i       (file_rd_i),
        .idx_i     (bit_idx_i),
        .cleared_o (bclr_res),
        .bit_val_o (bit_val)
    );

    // Purpose: result multiplexer.
    always_comb begin
        unique case (op)
            OP_ADD_WF, OP_DEC_F, OP_ADD_L: result = add_sum;
            OP_CLEAR_F:                    result = '0;
            OP_BIT_CLR:                    result = bclr_res;
            OP_LOAD_L:                     result = lit_i;
            default:                       result = file_rd_i;
        endcase
        res_zero = (result == '0);
    end

    // Purpose: next flag value from the operation's update class.
    always_comb begin
        flags_d = flags_q;
        if (upd_all) begin
            flags_d[FLG_C]  = add_c;
            flags_d[FLG_DC] = add_dc;
            flags_d[FLG_OV] = add_ov;
        end
        if (upd_all || upd_zn) begin
            flags_d[FLG_Z] = res_zero;
            flags_d[FLG_N] = result[DATA_W-1];
        end
    end

    // Purpose: W and status registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q     <= '0;
            flags_q <= '0;
        end else if (exec_i) begin
            if (wr_w) w_q <= result;
            flags_q <= flags_d;
        end
    end

    // Purpose: output drive.
    always_comb begin
        w_o       = w_q;
        status_o  = {{(STAT_W-FLG_CNT){1'b0}}, flags_q};
        file_we_o = exec_i && wr_f;
        file_wr_o = result;
        skip_o    = exec_i && (op == OP_BIT_TST) && !bit_val;
        br_nz_o   = !flags_q[FLG_Z];
        br_ov_o   = flags_q[FLG_OV];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (w_o == '0 && status_o == '0))
        else $error("reset did not clear W and status");

    // R2
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_W-1:FLG_CNT] == '0)
        else $error("unused status bits set");

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(w_o) && $stable(status_o)))
        else $error("state changed without execute");

    // R9
    skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (!file_we_o) ##1 ($stable(w_o) && $stable(status_o)))
        else $error("bit test wrote state");

    // R8
    bit_clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_BIT_CLR) |=> $stable(status_o))
        else $error("bit clear changed flags");

    // R5
    file_we_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        file_we_o |-> exec_i)
        else $error("file write without execute");

endmodule

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;

    typedef struct packed {
        logic [2:0] op;
        logic       dest;
        logic [7:0] w;
        logic [7:0] f;
        logic [7:0] lit;
        logic [2:0] bidx;
        logic       we;
        logic [7:0] res;
        logic       skip;
        logic [7:0] w_exp;
        logic [7:0] st_exp;
    } vec_t;

    localparam int NVEC = 16;
    // op dest w f lit bidx | we res skip w_exp status_exp
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 8'h0F, 8'h01, 8'h00, 3'd0, 1'b0, 8'h10, 1'b0, 8'h10, 8'h02},
        '{3'd0, 1'b1, 8'h80, 8'h80, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 8'h80, 8'h0D},
        '{3'd0, 1'b0, 8'h7F, 8'h01, 8'h00, 3'd0, 1'b0, 8'h80, 1'b0, 8'h80, 8'h1A},
        '{3'd1, 1'b1, 8'h33, 8'h00, 8'h00, 3'd0, 1'b1, 8'hFF, 1'b0, 8'h33, 8'h10},
        '{3'd1, 1'b0, 8'h33, 8'h01, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07},
        '{3'd1, 1'b0, 8'h33, 8'h80, 8'h00, 3'd0, 1'b0, 8'h7F, 1'b0, 8'h7F, 8'h09},
        '{3'd2, 1'b0, 8'h55, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h04},
        '{3'd2, 1'b1, 8'h11, 8'h9C, 8'h00, 3'd0, 1'b1, 8'h9C, 1'b0, 8'h11, 8'h10},
        '{3'd3, 1'b0, 8'h22, 8'h5A, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 8'h22, 8'h04},
        '{3'd4, 1'b0, 8'h01, 8'hFF, 8'h00, 3'd7, 1'b1, 8'h7F, 1'b0, 8'h01, 8'h00},
        '{3'd4, 1'b0, 8'h01, 8'h01, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 8'h01, 8'h00},
        '{3'd5, 1'b0, 8'h44, 8'hF7, 8'h00, 3'd3, 1'b0, 8'h00, 1'b1, 8'h44, 8'h00},
        '{3'd5, 1'b0, 8'h44, 8'h08, 8'h00, 3'd3, 1'b0, 8'h00, 1'b0, 8'h44, 8'h00},
        '{3'd6, 1'b0, 8'h00, 8'h00, 8'hA5, 3'd0, 1'b0, 8'h00, 1'b0, 8'hA5, 8'h00},
        '{3'd7, 1'b0, 8'hFF, 8'h00, 8'h01, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h07},
        '{3'd7, 1'b0, 8'h50, 8'h00, 8'h50, 3'd0, 1'b0, 8'h00, 1'b0, 8'hA0, 8'h18}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [2:0] op = 3'd0;
    logic       dest = 1'b0;
    logic [7:0] frd = 8'h00;
    logic [7:0] lit = 8'h00;
    logic [2:0] bidx = 3'd0;
    logic [7:0] w_o, status_o, file_wr_o;
    logic       file_we_o, skip_o, br_nz_o, br_ov_o;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    acc_alu_core i_acc_alu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_i    (exec),
        .op_i      (op),
        .dest_i    (dest),
        .file_rd_i (frd),
        .lit_i     (lit),
        .bit_idx_i (bidx),
        .w_o       (w_o),
        .status_o  (status_o),
        .file_we_o (file_we_o),
        .file_wr_o (file_wr_o),
        .skip_o    (skip_o),
        .br_nz_o   (br_nz_o),
        .br_ov_o   (br_ov_o)
    );

    task automatic check(input string rq, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd0, 3'd7: return "R3";
            3'd1:       return "R4";
            3'd2, 3'd3: return "R6";
            3'd4:       return "R8";
            3'd5:       return "R9";
            default:    return "R7";
        endcase
    endfunction

    // Presents an operation with exec high at a falling edge.
    task automatic present(input logic [2:0] o, input logic d, input logic [7:0] f,
                           input logic [7:0] l, input logic [2:0] b);
        @(negedge clk);
        op = o; dest = d; frd = f; lit = l; bidx = b; exec = 1'b1;
        #1;
    endtask

    // Ends the execute cycle: the rising edge passes, exec drops.
    task automatic finish_op();
        @(negedge clk);
        exec = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exec = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "w after reset", w_o, 8'h00);
        check("R1", "status after reset", status_o, 8'h00);
        check("R10", "br_nz after reset", {7'd0, br_nz_o}, 8'h01);
        check("R10", "br_ov after reset", {7'd0, br_ov_o}, 8'h00);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            present(3'd6, 1'b0, 8'h00, VECS[i].w, 3'd0);
            finish_op();
            present(VECS[i].op, VECS[i].dest, VECS[i].f, VECS[i].lit, VECS[i].bidx);
            check("R5", "file_we", {7'd0, file_we_o}, {7'd0, VECS[i].we});
            if (VECS[i].we) check(op_tag(VECS[i].op), "file data", file_wr_o, VECS[i].res);
            check(op_tag(VECS[i].op), "skip", {7'd0, skip_o}, {7'd0, VECS[i].skip});
            finish_op();
            check(op_tag(VECS[i].op), "w", w_o, VECS[i].w_exp);
            check("R2", "status", status_o, VECS[i].st_exp);
            check("R10", "br_nz", {7'd0, br_nz_o}, {7'd0, ~VECS[i].st_exp[2]});
            check("R10", "br_ov", {7'd0, br_ov_o}, {7'd0, VECS[i].st_exp[3]});
        end

        // Flags preserved across bit test and move (same-cycle interplay)
        do_reset();
        present(3'd6, 1'b0, 8'h00, 8'h80, 3'd0); finish_op();
        present(3'd0, 1'b1, 8'h80, 8'h00, 3'd0); finish_op();
        check("R3", "status after overflow add", status_o, 8'h0D);
        present(3'd5, 1'b0, 8'h00, 8'h00, 3'd2);
        check("R9", "skip with flags pending", {7'd0, skip_o}, 8'h01);
        check("R10", "br_ov during test", {7'd0, br_ov_o}, 8'h01);
        finish_op();
        check("R9", "status after bit test", status_o, 8'h0D);
        present(3'd6, 1'b0, 8'h00, 8'h3C, 3'd0); finish_op();
        check("R7", "status after literal load", status_o, 8'h0D);
        check("R7", "w after literal load", w_o, 8'h3C);
        present(3'd2, 1'b0, 8'h80, 8'h00, 3'd0); finish_op();
        check("R6", "move keeps C/OV", status_o, 8'h19);
        check("R10", "br_nz after move", {7'd0, br_nz_o}, 8'h01);

        // R11: exec low ignores an operation
        @(negedge clk);
        op = 3'd5; frd = 8'h00; bidx = 3'd0; lit = 8'hEE; exec = 1'b0;
        #1;
        check("R11", "skip while idle", {7'd0, skip_o}, 8'h00);
        op = 3'd3; #1;
        check("R11", "file_we while idle", {7'd0, file_we_o}, 8'h00);
        op = 3'd7;
        @(negedge clk); #1;
        check("R11", "w while idle", w_o, 8'h80);
        check("R11", "status while idle", status_o, 8'h19);

        // R1: reset mid-run with exec high
        @(negedge clk);
        rst_n = 1'b0; exec = 1'b1; op = 3'd7; lit = 8'h01;
        @(negedge clk);
        exec = 1'b0; rst_n = 1'b1; #1;
        check("R1", "w after mid reset", w_o, 8'h00);
        check("R1", "status after mid reset", status_o, 8'h00);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule